// File: doc/BRIEF.md
# Host buffer flow-control manager

This block keeps the bookkeeping for two circular rings of page-sized buffers in DRAM: a read ring, which flash reads fill and the host link drains, and a write ring, which the host link fills and flash programs drain. Each ring has a limit pointer. The read limit marks how far flash has filled the read ring in order. The write limit marks how far flash has drained the write ring in order. The host-side pointers come in from the host link.

Flash banks report finished transfers as completion messages that carry a buffer ID. These messages may arrive in any order. The block records them in a per-buffer bitmap and moves each limit forward over consecutive finished buffers only. Firmware can overwrite either limit to skip a buffer that will never complete.

From these pointers the block gates four kinds of transfer: host reads, host writes, flash reads into a buffer and flash writes out of a buffer. A flash write can be queued before the host has supplied its data, and it is held until the host write pointer has moved past that buffer. The block also converts a flash DMA address into a buffer ID, and it produces the DRAM start address of the current host transfer on each ring.

Top module: `hbuf_flow_ctl`

## Requirements
- R1: While reset is asserted, both limit pointers are 0 (wrap bit 0, index 0) and no buffer is marked finished. Right after reset, `host_wr_go_o` is 1 and `host_rd_go_o` is 0.
- R2: The buffer ID of a flash request is `(req_addr - ring_base) >> pg_log2_i`, truncated to ID_W bits. The page size is 2^pg_log2_i bytes and pg_log2_i is at least 9. IDs restart at 0 in each ring.
- R3: The host transfer start address of a ring is `base + idx*2^k + (sect_off mod 2^(k-9))*512`, where k is pg_log2_i and idx is the index field of that ring's host pointer.
- R4: Let occ be the write occupancy (host write pointer minus write limit) and off be the distance, modulo the ring size, from the write-limit index to the requested ID. `fl_wr_go_o` is 1 exactly when off < occ. For example, with the limit at 0, buffer 7 goes once the pointer is 8 and stalls while the pointer is 7.
- R5: A write completion for ID n sets the finished bit of n on the next edge. On each edge where the bit at the write-limit index is set and no override is applied, that bit clears and the limit steps once. The limit never passes a buffer whose completion is missing, so it moves 2 edges after a completion for its current index is presented.
- R6: The read limit follows the same rule as R5, driven by the read completion inputs.
- R7: `host_wr_go_o` is 1 exactly when the write occupancy is less than the ring size. `host_rd_go_o` is 1 exactly when the read limit differs from the host read pointer.
- R8: `fl_rd_go_o` is 1 exactly when the distance from the host-read index to the requested ID, modulo the ring size, is at least the read occupancy (read limit minus host read pointer). The buffer the host is reading is therefore never handed to flash while data is pending.
- R9: On an edge where `ovr_trig_i[0]` is 1, the write limit is loaded from `ovr_wr_set_i`. Bit 1 loads the read limit from `ovr_rd_set_i`. A value of 3 loads both on the same edge.
- R10: When an override and an automatic advance fall on the same edge for a ring, the override value wins. The finished bit at the old index is left set.
- R11: Pointers are {wrap, index}, with the index in 0..ring size-1. Stepping from index ring size-1 gives index 0 with the wrap bit inverted. Equal pointers mean empty, and the same index with a different wrap bit means full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pg_log2_i | input | PGL_W | log2 of buffer size in bytes (>= 9) |
| rd_base_i | input | ADDR_W | Read ring base address |
| wr_base_i | input | ADDR_W | Write ring base address |
| rd_ring_sz_i | input | ID_W+1 | Read ring buffer count (1..2^ID_W) |
| wr_ring_sz_i | input | ID_W+1 | Write ring buffer count (1..2^ID_W) |
| host_rd_ptr_i | input | ID_W+1 | Host read pointer {wrap, index} |
| host_wr_ptr_i | input | ID_W+1 | Host write pointer {wrap, index} |
| sect_off_i | input | SECT_W | Host sector offset |
| rd_cmp_vld_i | input | NBANK | Per-bank read completion valid |
| rd_cmp_id_i | input | NBANK*ID_W | Per-bank read completion buffer IDs |
| wr_cmp_vld_i | input | NBANK | Per-bank write completion valid |
| wr_cmp_id_i | input | NBANK*ID_W | Per-bank write completion buffer IDs |
| fl_rd_addr_i | input | ADDR_W | DMA address of a flash read request |
| fl_wr_addr_i | input | ADDR_W | DMA address of a flash write request |
| ovr_trig_i | input | 2 | Override trigger: bit 0 write limit, bit 1 read limit |
| ovr_rd_set_i | input | ID_W+1 | Forced read limit value |
| ovr_wr_set_i | input | ID_W+1 | Forced write limit value |
| rd_limit_o | output | ID_W+1 | Read limit pointer |
| wr_limit_o | output | ID_W+1 | Write limit pointer |
| host_rd_go_o | output | 1 | Host read transfer may proceed |
| host_wr_go_o | output | 1 | Host write transfer may proceed |
| fl_rd_go_o | output | 1 | Flash read into requested buffer may proceed |
| fl_wr_go_o | output | 1 | Flash write from requested buffer may proceed |
| fl_rd_id_o | output | ID_W | Buffer ID of flash read request |
| fl_wr_id_o | output | ID_W | Buffer ID of flash write request |
| host_rd_addr_o | output | ADDR_W | Host read transfer start address |
| host_wr_addr_o | output | ADDR_W | Host write transfer start address |

## Verification
Completions are tested in three directed patterns. In-order arrivals show that the limit steps once per edge. A later ID arriving before an earlier one shows that the bitmap holds the later ID back until the gap is filled. A run that crosses the last index shows that the wrap bit inverts. Further directed cases pit an override against a pending advance and place a flash write request on either side of the host pointer (buffer 7 with the pointer at 7 and at 8). Random segments then change the ring size to values that are not powers of two, along with the page size, bases, sector offsets and host pointers, and mix multi-bank completions with sparse overrides. This separates modular distance errors from errors confined to power-of-two rings.

// File: rtl/hbuf_pkg.sv
package hbuf_pkg;
  localparam int unsigned SECT_LOG2 = 9;
  typedef enum int unsigned { SIDE_RD = 0, SIDE_WR = 1 } side_e;
endpackage

// File: rtl/hbuf_limit_trk.sv
module hbuf_limit_trk #(
  parameter int unsigned ID_W  = 6,
  parameter int unsigned NBANK = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ID_W:0]         ring_sz_i,
  input  logic [NBANK-1:0]      cmp_vld_i,
  input  logic [NBANK*ID_W-1:0] cmp_id_i,
  input  logic                  ovr_i,
  input  logic [ID_W:0]         ovr_val_i,
  output logic [ID_W:0]         limit_o
);
  localparam int unsigned DEPTH = 1 << ID_W;

  logic [DEPTH-1:0] done_q, done_d, set_vec;
  logic [ID_W:0]    lim_q, lim_d, lim_nxt;
  logic             adv;

  always_comb begin
    set_vec = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (cmp_vld_i[b]) set_vec[cmp_id_i[b*ID_W +: ID_W]] = 1'b1;
    end
  end

  // step with wrap at ring end
  always_comb begin
    if ({1'b0, lim_q[ID_W-1:0]} == ring_sz_i - 1'b1)
      lim_nxt = {~lim_q[ID_W], {ID_W{1'b0}}};
    else
      lim_nxt = {lim_q[ID_W], lim_q[ID_W-1:0] + 1'b1};
  end

  assign adv = done_q[lim_q[ID_W-1:0]] && !ovr_i;

  always_comb begin
    done_d = done_q;
    if (adv) done_d[lim_q[ID_W-1:0]] = 1'b0;
    done_d = done_d | set_vec;
    if (ovr_i)    lim_d = ovr_val_i;
    else if (adv) lim_d = lim_nxt;
    else          lim_d = lim_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= '0;
      lim_q  <= '0;
    end else begin
      done_q <= done_d;
      lim_q  <= lim_d;
    end
  end

  assign limit_o = lim_q;
endmodule

// File: rtl/hbuf_addr_gen.sv
module hbuf_addr_gen #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned ID_W   = 6,
  parameter int unsigned SECT_W = 16,
  parameter int unsigned PGL_W  = 5
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ID_W-1:0]   ptr_idx_i,
  input  logic [SECT_W-1:0] sect_i,
  input  logic [PGL_W-1:0]  pg_log2_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic [ADDR_W-1:0] xfer_addr_o,
  output logic [ID_W-1:0]   req_id_o
);
  import hbuf_pkg::*;

  logic [PGL_W-1:0]  spp_log2;
  logic [ADDR_W-1:0] spp_mask, sect_ext, page_off, rel, rel_sh;

  assign spp_log2 = pg_log2_i - PGL_W'(SECT_LOG2);
  assign spp_mask = (ADDR_W'(1) << spp_log2) - ADDR_W'(1);
  assign sect_ext = ADDR_W'(sect_i) & spp_mask;
  assign page_off = ADDR_W'(ptr_idx_i) << pg_log2_i;
  assign xfer_addr_o = base_i + page_off + (sect_ext << SECT_LOG2);

  assign rel    = req_addr_i - base_i;
  assign rel_sh = rel >> pg_log2_i;
  assign req_id_o = rel_sh[ID_W-1:0];
endmodule

// File: rtl/hbuf_gate.sv
module hbuf_gate #(
  parameter int unsigned ID_W = 6
) (
  input  logic [ID_W:0]   rd_ring_i,
  input  logic [ID_W:0]   wr_ring_i,
  input  logic [ID_W:0]   rd_lim_i,
  input  logic [ID_W:0]   wr_lim_i,
  input  logic [ID_W:0]   host_rd_ptr_i,
  input  logic [ID_W:0]   host_wr_ptr_i,
  input  logic [ID_W-1:0] fl_rd_id_i,
  input  logic [ID_W-1:0] fl_wr_id_i,
  output logic            host_rd_go_o,
  output logic            host_wr_go_o,
  output logic            fl_rd_go_o,
  output logic            fl_wr_go_o
);
  localparam int unsigned PTR_W = ID_W + 1;

  function automatic logic [PTR_W-1:0] occ(input logic [PTR_W-1:0] a,
                                           input logic [PTR_W-1:0] b,
                                           input logic [PTR_W-1:0] ring);
    logic [PTR_W:0] s;
    if (a[ID_W] == b[ID_W]) s = {2'b0, b[ID_W-1:0]} - {2'b0, a[ID_W-1:0]};
    else s = {2'b0, b[ID_W-1:0]} + {1'b0, ring} - {2'b0, a[ID_W-1:0]};
    return s[PTR_W-1:0];
  endfunction

  function automatic logic [PTR_W-1:0] off(input logic [ID_W-1:0] a,
                                           input logic [ID_W-1:0] n,
                                           input logic [PTR_W-1:0] ring);
    logic [PTR_W:0] s;
    if (n >= a) s = {2'b0, n} - {2'b0, a};
    else        s = {2'b0, n} + {1'b0, ring} - {2'b0, a};
    return s[PTR_W-1:0];
  endfunction

  logic [PTR_W-1:0] wr_occ, rd_occ;

  assign wr_occ = occ(wr_lim_i, host_wr_ptr_i, wr_ring_i);
  assign rd_occ = occ(host_rd_ptr_i, rd_lim_i, rd_ring_i);

  assign host_wr_go_o = wr_occ < wr_ring_i;
  assign host_rd_go_o = rd_occ != '0;
  assign fl_wr_go_o   = off(wr_lim_i[ID_W-1:0], fl_wr_id_i, wr_ring_i) < wr_occ;
  assign fl_rd_go_o   = off(host_rd_ptr_i[ID_W-1:0], fl_rd_id_i, rd_ring_i) >= rd_occ;
endmodule

// File: rtl/hbuf_flow_ctl.sv
module hbuf_flow_ctl #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned ID_W   = 6,
  parameter int unsigned NBANK  = 4,
  parameter int unsigned SECT_W = 16,
  parameter int unsigned PGL_W  = 5
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [PGL_W-1:0]      pg_log2_i,
  input  logic [ADDR_W-1:0]     rd_base_i,
  input  logic [ADDR_W-1:0]     wr_base_i,
  input  logic [ID_W:0]         rd_ring_sz_i,
  input  logic [ID_W:0]         wr_ring_sz_i,
  input  logic [ID_W:0]         host_rd_ptr_i,
  input  logic [ID_W:0]         host_wr_ptr_i,
  input  logic [SECT_W-1:0]     sect_off_i,
  input  logic [NBANK-1:0]      rd_cmp_vld_i,
  input  logic [NBANK*ID_W-1:0] rd_cmp_id_i,
  input  logic [NBANK-1:0]      wr_cmp_vld_i,
  input  logic [NBANK*ID_W-1:0] wr_cmp_id_i,
  input  logic [ADDR_W-1:0]     fl_rd_addr_i,
  input  logic [ADDR_W-1:0]     fl_wr_addr_i,
  input  logic [1:0]            ovr_trig_i,
  input  logic [ID_W:0]         ovr_rd_set_i,
  input  logic [ID_W:0]         ovr_wr_set_i,
  output logic [ID_W:0]         rd_limit_o,
  output logic [ID_W:0]         wr_limit_o,
  output logic                  host_rd_go_o,
  output logic                  host_wr_go_o,
  output logic                  fl_rd_go_o,
  output logic                  fl_wr_go_o,
  output logic [ID_W-1:0]       fl_rd_id_o,
  output logic [ID_W-1:0]       fl_wr_id_o,
  output logic [ADDR_W-1:0]     host_rd_addr_o,
  output logic [ADDR_W-1:0]     host_wr_addr_o
);
  import hbuf_pkg::*;

  localparam int unsigned NSIDE = 2;

  logic [ID_W:0]         ring_a    [NSIDE];
  logic [ID_W:0]         lim_a     [NSIDE];
  logic [ID_W:0]         ovr_set_a [NSIDE];
  logic [ID_W:0]         hptr_a    [NSIDE];
  logic [NBANK-1:0]      cvld_a    [NSIDE];
  logic [NBANK*ID_W-1:0] cid_a     [NSIDE];
  logic [ADDR_W-1:0]     base_a    [NSIDE];
  logic [ADDR_W-1:0]     req_a     [NSIDE];
  logic [ADDR_W-1:0]     xfer_a    [NSIDE];
  logic [ID_W-1:0]       rid_a     [NSIDE];

  assign ring_a[SIDE_RD]    = rd_ring_sz_i;
  assign ring_a[SIDE_WR]    = wr_ring_sz_i;
  assign ovr_set_a[SIDE_RD] = ovr_rd_set_i;
  assign ovr_set_a[SIDE_WR] = ovr_wr_set_i;
  assign hptr_a[SIDE_RD]    = host_rd_ptr_i;
  assign hptr_a[SIDE_WR]    = host_wr_ptr_i;
  assign cvld_a[SIDE_RD]    = rd_cmp_vld_i;
  assign cvld_a[SIDE_WR]    = wr_cmp_vld_i;
  assign cid_a[SIDE_RD]     = rd_cmp_id_i;
  assign cid_a[SIDE_WR]     = wr_cmp_id_i;
  assign base_a[SIDE_RD]    = rd_base_i;
  assign base_a[SIDE_WR]    = wr_base_i;
  assign req_a[SIDE_RD]     = fl_rd_addr_i;
  assign req_a[SIDE_WR]     = fl_wr_addr_i;

  // ovr_trig_i bit 0 -> write ring, bit 1 -> read ring
  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    localparam int unsigned TRIG_BIT = (g == SIDE_WR) ? 0 : 1;

    hbuf_limit_trk #(.ID_W(ID_W), .NBANK(NBANK)) u_trk (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ring_sz_i (ring_a[g]),
      .cmp_vld_i (cvld_a[g]),
      .cmp_id_i  (cid_a[g]),
      .ovr_i     (ovr_trig_i[TRIG_BIT]),
      .ovr_val_i (ovr_set_a[g]),
      .limit_o   (lim_a[g])
    );

    hbuf_addr_gen #(.ADDR_W(ADDR_W), .ID_W(ID_W), .SECT_W(SECT_W), .PGL_W(PGL_W)) u_addr (
      .base_i      (base_a[g]),
      .ptr_idx_i   (hptr_a[g][ID_W-1:0]),
      .sect_i      (sect_off_i),
      .pg_log2_i   (pg_log2_i),
      .req_addr_i  (req_a[g]),
      .xfer_addr_o (xfer_a[g]),
      .req_id_o    (rid_a[g])
    );
  end

  hbuf_gate #(.ID_W(ID_W)) u_gate (
    .rd_ring_i     (rd_ring_sz_i),
    .wr_ring_i     (wr_ring_sz_i),
    .rd_lim_i      (lim_a[SIDE_RD]),
    .wr_lim_i      (lim_a[SIDE_WR]),
    .host_rd_ptr_i (host_rd_ptr_i),
    .host_wr_ptr_i (host_wr_ptr_i),
    .fl_rd_id_i    (rid_a[SIDE_RD]),
    .fl_wr_id_i    (rid_a[SIDE_WR]),
    .host_rd_go_o  (host_rd_go_o),
    .host_wr_go_o  (host_wr_go_o),
    .fl_rd_go_o    (fl_rd_go_o),
    .fl_wr_go_o    (fl_wr_go_o)
  );

  assign rd_limit_o     = lim_a[SIDE_RD];
  assign wr_limit_o     = lim_a[SIDE_WR];
  assign fl_rd_id_o     = rid_a[SIDE_RD];
  assign fl_wr_id_o     = rid_a[SIDE_WR];
  assign host_rd_addr_o = xfer_a[SIDE_RD];
  assign host_wr_addr_o = xfer_a[SIDE_WR];
endmodule

// File: rtl/hbuf_flow_chk.sv
module hbuf_flow_chk #(
  parameter int unsigned ID_W = 6
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [ID_W:0]   rd_ring_sz_i,
  input logic [ID_W:0]   wr_ring_sz_i,
  input logic [ID_W:0]   host_rd_ptr_i,
  input logic [ID_W:0]   host_wr_ptr_i,
  input logic [1:0]      ovr_trig_i,
  input logic [ID_W:0]   ovr_rd_set_i,
  input logic [ID_W:0]   ovr_wr_set_i,
  input logic [ID_W:0]   rd_limit_o,
  input logic [ID_W:0]   wr_limit_o,
  input logic            host_rd_go_o,
  input logic            fl_rd_go_o,
  input logic            fl_wr_go_o,
  input logic [ID_W-1:0] fl_rd_id_o
);
  function automatic logic [ID_W:0] step(input logic [ID_W:0] p, input logic [ID_W:0] ring);
    if ({1'b0, p[ID_W-1:0]} == ring - 1'b1) return {~p[ID_W], {ID_W{1'b0}}};
    return {p[ID_W], p[ID_W-1:0] + 1'b1};
  endfunction

  // R5: write limit holds or steps once
  a_r5_wr_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovr_trig_i[0] |=> (wr_limit_o == $past(wr_limit_o)) ||
                       (wr_limit_o == step($past(wr_limit_o), $past(wr_ring_sz_i))));

  // R6: read limit holds or steps once
  a_r6_rd_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovr_trig_i[1] |=> (rd_limit_o == $past(rd_limit_o)) ||
                       (rd_limit_o == step($past(rd_limit_o), $past(rd_ring_sz_i))));

  // R9: forced loads
  a_r9_wr_force: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_trig_i[0] |=> wr_limit_o == $past(ovr_wr_set_i));

  a_r9_rd_force: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_trig_i[1] |=> rd_limit_o == $past(ovr_rd_set_i));

  // R4: any flash write go implies host data present
  a_r4_wr_needs_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_wr_go_o |-> host_wr_ptr_i != wr_limit_o);

  // R8: buffer under host read never handed to flash
  a_r8_no_refill_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_rd_go_o && host_rd_go_o) |-> fl_rd_id_o != host_rd_ptr_i[ID_W-1:0]);
endmodule

bind hbuf_flow_ctl hbuf_flow_chk #(.ID_W(ID_W)) u_flow_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rd_ring_sz_i  (rd_ring_sz_i),
  .wr_ring_sz_i  (wr_ring_sz_i),
  .host_rd_ptr_i (host_rd_ptr_i),
  .host_wr_ptr_i (host_wr_ptr_i),
  .ovr_trig_i    (ovr_trig_i),
  .ovr_rd_set_i  (ovr_rd_set_i),
  .ovr_wr_set_i  (ovr_wr_set_i),
  .rd_limit_o    (rd_limit_o),
  .wr_limit_o    (wr_limit_o),
  .host_rd_go_o  (host_rd_go_o),
  .fl_rd_go_o    (fl_rd_go_o),
  .fl_wr_go_o    (fl_wr_go_o),
  .fl_rd_id_o    (fl_rd_id_o)
);

// File: tb/hbuf_flow_ctl_bench.sv
module hbuf_flow_ctl_bench;
  localparam int ADDR_W = 32;
  localparam int ID_W   = 6;
  localparam int NBANK  = 4;
  localparam int SECT_W = 16;
  localparam int PGL_W  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [PGL_W-1:0]      pg_log2;
  logic [ADDR_W-1:0]     rd_base, wr_base, fl_rd_addr, fl_wr_addr;
  logic [ID_W:0]         rd_ring, wr_ring, hrp, hwp, ovr_rd, ovr_wr;
  logic [SECT_W-1:0]     sect;
  logic [NBANK-1:0]      rd_vld, wr_vld;
  logic [NBANK*ID_W-1:0] rd_ids, wr_ids;
  logic [1:0]            ovr;
  logic [ID_W:0]         rd_lim, wr_lim;
  logic                  h_rd_go, h_wr_go, f_rd_go, f_wr_go;
  logic [ID_W-1:0]       f_rd_id, f_wr_id;
  logic [ADDR_W-1:0]     h_rd_addr, h_wr_addr;

  hbuf_flow_ctl #(.ADDR_W(ADDR_W), .ID_W(ID_W), .NBANK(NBANK), .SECT_W(SECT_W), .PGL_W(PGL_W))
  u_hbuf_flow_ctl (
    .clk_i(clk), .rst_ni(rst_n), .pg_log2_i(pg_log2),
    .rd_base_i(rd_base), .wr_base_i(wr_base),
    .rd_ring_sz_i(rd_ring), .wr_ring_sz_i(wr_ring),
    .host_rd_ptr_i(hrp), .host_wr_ptr_i(hwp), .sect_off_i(sect),
    .rd_cmp_vld_i(rd_vld), .rd_cmp_id_i(rd_ids),
    .wr_cmp_vld_i(wr_vld), .wr_cmp_id_i(wr_ids),
    .fl_rd_addr_i(fl_rd_addr), .fl_wr_addr_i(fl_wr_addr),
    .ovr_trig_i(ovr), .ovr_rd_set_i(ovr_rd), .ovr_wr_set_i(ovr_wr),
    .rd_limit_o(rd_lim), .wr_limit_o(wr_lim),
    .host_rd_go_o(h_rd_go), .host_wr_go_o(h_wr_go),
    .fl_rd_go_o(f_rd_go), .fl_wr_go_o(f_wr_go),
    .fl_rd_id_o(f_rd_id), .fl_wr_id_o(f_wr_id),
    .host_rd_addr_o(h_rd_addr), .host_wr_addr_o(h_wr_addr)
  );

  int checks = 0;
  int fails  = 0;
  bit done_run = 1'b0;

  // reference model state
  logic [ID_W:0] m_rl, m_wl;
  logic [63:0]   m_rdone, m_wdone;
  int unsigned   fl_rd_exp_id, fl_wr_exp_id;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [ID_W:0] m_step(input logic [ID_W:0] p, input logic [ID_W:0] ring);
    int unsigned i = p[ID_W-1:0];
    if (i + 1 == ring) return {~p[ID_W], 6'd0};
    return {p[ID_W], 6'(i + 1)};
  endfunction

  function automatic int unsigned m_occ(input logic [ID_W:0] a, input logic [ID_W:0] b, input int unsigned ring);
    int unsigned ai = a[ID_W-1:0];
    int unsigned bi = b[ID_W-1:0];
    if (a[ID_W] == b[ID_W]) return bi - ai;
    return bi + ring - ai;
  endfunction

  function automatic int unsigned m_off(input int unsigned a, input int unsigned n, input int unsigned ring);
    return (n >= a) ? n - a : n + ring - a;
  endfunction

  function automatic logic [ADDR_W-1:0] m_xfer(input logic [ADDR_W-1:0] base, input int unsigned idx,
                                              input int unsigned sct, input int unsigned k);
    int unsigned spp = 1 << (k - 9);
    return base + ADDR_W'(idx << k) + ADDR_W'((sct % spp) * 512);
  endfunction

  // check combinational outputs, then advance model across the next edge
  task automatic step();
    int unsigned rocc, wocc;
    bit radv, wadv;
    #1;
    rocc = m_occ(hrp, m_rl, rd_ring);
    wocc = m_occ(m_wl, hwp, wr_ring);
    chk("R6 rd_limit", rd_lim, m_rl);
    chk("R5 wr_limit", wr_lim, m_wl);
    chk("R7 host_rd_go", h_rd_go, (rocc != 0));
    chk("R7 host_wr_go", h_wr_go, (wocc < wr_ring));
    chk("R2 fl_rd_id", f_rd_id, fl_rd_exp_id);
    chk("R2 fl_wr_id", f_wr_id, fl_wr_exp_id);
    chk("R4 fl_wr_go", f_wr_go, (m_off(m_wl[ID_W-1:0], fl_wr_exp_id, wr_ring) < wocc));
    chk("R8 fl_rd_go", f_rd_go, (m_off(hrp[ID_W-1:0], fl_rd_exp_id, rd_ring) >= rocc));
    chk("R3 host_rd_addr", h_rd_addr, m_xfer(rd_base, hrp[ID_W-1:0], sect, pg_log2));
    chk("R3 host_wr_addr", h_wr_addr, m_xfer(wr_base, hwp[ID_W-1:0], sect, pg_log2));
    radv = m_rdone[m_rl[ID_W-1:0]] && !ovr[1];
    wadv = m_wdone[m_wl[ID_W-1:0]] && !ovr[0];
    if (radv) m_rdone[m_rl[ID_W-1:0]] = 1'b0;
    if (wadv) m_wdone[m_wl[ID_W-1:0]] = 1'b0;
    if (ovr[1]) m_rl = ovr_rd; else if (radv) m_rl = m_step(m_rl, rd_ring);
    if (ovr[0]) m_wl = ovr_wr; else if (wadv) m_wl = m_step(m_wl, wr_ring);
    for (int b = 0; b < NBANK; b++) begin
      if (rd_vld[b]) m_rdone[rd_ids[b*ID_W +: ID_W]] = 1'b1;
      if (wr_vld[b]) m_wdone[wr_ids[b*ID_W +: ID_W]] = 1'b1;
    end
    @(negedge clk);
  endtask

  task automatic set_req(input int unsigned rid, input int unsigned wid);
    fl_rd_exp_id = rid;
    fl_wr_exp_id = wid;
    fl_rd_addr = rd_base + ADDR_W'(rid << pg_log2) + ADDR_W'($urandom % (1 << pg_log2));
    fl_wr_addr = wr_base + ADDR_W'(wid << pg_log2) + ADDR_W'($urandom % (1 << pg_log2));
  endtask

  task automatic idle_in();
    rd_vld = '0; wr_vld = '0; ovr = 2'b00;
  endtask

  task automatic wr_cmp1(input int unsigned id);
    wr_vld = 4'b0001; wr_ids = '0; wr_ids[ID_W-1:0] = 6'(id);
  endtask

  initial begin
    void'($urandom(32'd4711));
    pg_log2 = 5'd12; rd_base = 32'h1000_0000; wr_base = 32'h2000_0000;
    rd_ring = 7'd16; wr_ring = 7'd16; hrp = '0; hwp = '0; sect = '0;
    rd_ids = '0; wr_ids = '0; ovr_rd = '0; ovr_wr = '0;
    idle_in();
    m_rl = '0; m_wl = '0; m_rdone = '0; m_wdone = '0;
    set_req(0, 0);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 rd_limit reset", rd_lim, 0);
    chk("R1 wr_limit reset", wr_lim, 0);
    rst_n = 1'b1;
    #1;
    chk("R1 host_wr_go after reset", h_wr_go, 1);
    chk("R1 host_rd_go after reset", h_rd_go, 0);
    @(negedge clk);
    step();

    // R4: buffer 7 with host pointer at 7 then 8
    hwp = 7'd7; set_req(0, 7); #1;
    chk("R4 buf7 ptr7 stall", f_wr_go, 0);
    step();
    hwp = 7'd8; #1;
    chk("R4 buf7 ptr8 go", f_wr_go, 1);
    step();

    // R5: out of order, 1 before 0
    wr_cmp1(1); step(); idle_in();
    step();
    chk("R5 hold on gap", wr_lim, 0);
    wr_cmp1(0); step(); idle_in();
    step(); step();
    chk("R5 ran over both", wr_lim, 2);

    // R10: pending advance vs override
    wr_cmp1(2); step(); idle_in();
    ovr = 2'b01; ovr_wr = 7'd5; step(); idle_in();
    chk("R10 override wins", wr_lim, 5);
    // R9: both at once
    ovr = 2'b11; ovr_wr = 7'd3; ovr_rd = 7'd4; step(); idle_in();
    chk("R9 wr forced", wr_lim, 3);
    chk("R9 rd forced", rd_lim, 4);
    ovr = 2'b11; ovr_wr = 7'd0; ovr_rd = 7'd0; step(); idle_in();
    m_wdone = '0; m_rdone = '0;

    // R11: wrap on 3-entry ring (clear stale bits by consuming)
    wr_ring = 7'd3; rd_ring = 7'd3; hwp = 7'd0; hrp = 7'd0; set_req(0, 0);
    wr_vld = 4'b0111; wr_ids = {6'd0, 6'd2, 6'd1, 6'd0}; step(); idle_in();
    step(); step(); step();
    chk("R11 wrap bit set", wr_lim, 7'h40);

    // random segments
    for (int seg = 0; seg < 12; seg++) begin
      int unsigned rr = 1 + ($urandom % 64);
      int unsigned wr = 1 + ($urandom % 64);
      rd_ring = 7'(rr); wr_ring = 7'(wr);
      pg_log2 = 5'(9 + ($urandom % 5));
      rd_base = $urandom; wr_base = $urandom;
      hrp = '0; hwp = '0; set_req(0, 0);
      idle_in(); ovr = 2'b11; ovr_rd = '0; ovr_wr = '0; step();
      for (int i = 0; i < 600; i++) begin
        idle_in();
        rd_vld = 4'($urandom); wr_vld = 4'($urandom);
        for (int b = 0; b < NBANK; b++) begin
          rd_ids[b*ID_W +: ID_W] = 6'($urandom % rr);
          wr_ids[b*ID_W +: ID_W] = 6'($urandom % wr);
        end
        if ($urandom % 40 == 0) begin
          ovr = 2'($urandom);
          ovr_rd = {1'($urandom), 6'($urandom % rr)};
          ovr_wr = {1'($urandom), 6'($urandom % wr)};
        end
        hrp = {1'($urandom), 6'($urandom % rr)};
        hwp = {1'($urandom), 6'($urandom % wr)};
        sect = SECT_W'($urandom);
        set_req($urandom % rr, $urandom % wr);
        step();
      end
    end
    done_run = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_run) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule